// File: doc/BRIEF.md
# Dual-Pixel Raster Timing Generator

This block produces the raster timing for a 1600x1200 flat panel that takes two horizontally adjacent pixels on every clock. One port carries the even pixel (the first of the pair) and the other carries the odd pixel (the second). All horizontal counts are therefore in pixel-pair clocks. A line of 1600 dots is 800 clocks. The block walks a horizontal and a vertical counter through sync, back porch, active and front porch. From them it drives horizontal sync, vertical sync and a data-enable strobe. It also gives a pair-column index and a row index, so that an upstream pixel source can fetch the right even/odd pair.

All interval lengths are parameters. The defaults give the common 60 Hz mode: 1080 clocks per line and 1250 lines per frame. A second, reduced-blanking preset (912 clocks by 1214 lines) is chosen with a mode input. A change of mode is taken only at a frame boundary. Sync polarity is selectable per direction. Every output is a register clocked by the pixel-pair clock, and both pixel ports share this one set of timing.

Top module: `dual_pixel_timing_gen`

## Requirements
- R1: A synchronous reset clears both counters and loads the mode input. During reset both syncs sit at their inactive level, data enable is 0, and both indices are 0. Outputs lag the raster position by one clock, so the first clock after reset presents position (line 0, clock 0), with both syncs active.
- R2: In the standard preset each line is H_SYNC_STD + H_BACK_STD + H_ACTIVE_PAIRS + H_FRONT_STD clocks, in the order sync, back porch, active, front porch. Horizontal sync is active for the first H_SYNC_STD clocks of every line.
- R3: The vertical count advances on the last clock of each line. In the standard preset a frame is V_SYNC_STD + V_BACK_STD + V_ACTIVE + V_FRONT_STD lines in the same order. Vertical sync is active for all clocks of the first V_SYNC_STD lines.
- R4: Data enable is 1 exactly on active clocks of active lines, and 0 everywhere else.
- R5: While data enable is 1, the pair-column index starts at 0 and rises by 1 each clock up to H_ACTIVE_PAIRS-1. Pair k carries dot 2k on the even port and dot 2k+1 on the odd port.
- R6: While data enable is 1, the row index equals the active line number (0 to V_ACTIVE-1) and stays constant within a line.
- R7: Both indices are 0 whenever data enable is 0.
- R8: A polarity input at 1 makes its sync active-high; at 0 the sync is active-low. A change shows on the output from the next clock.
- R9: Mode input 1 selects the reduced-blanking preset (the *_RB lengths) and 0 selects the standard preset. The input is sampled only at reset and on the last clock of a frame. A change in mid-frame has no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 1 | 0 standard preset, 1 reduced-blanking preset |
| hSyncPolHigh | input | 1 | 1 active-high horizontal sync, 0 active-low |
| vSyncPolHigh | input | 1 | 1 active-high vertical sync, 0 active-low |
| hSyncOut | output | 1 | Horizontal sync |
| vSyncOut | output | 1 | Vertical sync |
| dataEnable | output | 1 | High while the pixel pair is to be displayed |
| pairCol | output | $clog2(H_ACTIVE_PAIRS) | Pixel-pair column index |
| lineRow | output | $clog2(V_ACTIVE) | Active row index |

## Verification
The hardest condition to reach from the ports is a mode request that arrives part-way through a frame. The preset must not change until the frame's last clock, and it must change cleanly at that boundary. A mid-frame reset must also be followed by a clean restart. At default lengths one frame alone would exceed the run budget. The bench therefore shrinks every interval to a few clocks, so that hundreds of frame boundaries pass in one run. It then flips the mode, both polarities and the reset at random cycles. A bench model of the raster, advanced once per clock, compares all five outputs on every cycle.

// File: rtl/dpvt_pkg.sv
package dpvt_pkg;

  // Per-clock raster strobes handed from control to datapath
  typedef struct packed {
    logic hSync;    // horizontal counter inside its sync interval
    logic vSync;    // vertical counter inside its sync interval
    logic hAct;     // horizontal counter inside the active interval
    logic vAct;     // vertical counter inside the active interval
    logic lineEnd;  // last clock of the current line
  } rasterStrobes_t;

endpackage

// File: rtl/dpvt_axis.sv
// One raster axis: a wrapping counter with interval decode for two presets.
module dpvt_axis #(
  parameter int W       = 11,
  parameter int SYNC_A  = 96,
  parameter int BACK_A  = 152,
  parameter int ACT     = 800,
  parameter int FRONT_A = 32,
  parameter int SYNC_B  = 8,
  parameter int BACK_B  = 56,
  parameter int FRONT_B = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic useAlt,
  output logic inSync,
  output logic inAct,
  output logic atLast
);

  localparam logic [W-1:0] SYNC_END_A  = W'(SYNC_A);
  localparam logic [W-1:0] ACT_START_A = W'(SYNC_A + BACK_A);
  localparam logic [W-1:0] ACT_END_A   = W'(SYNC_A + BACK_A + ACT);
  localparam logic [W-1:0] LAST_A      = W'(SYNC_A + BACK_A + ACT + FRONT_A - 1);
  localparam logic [W-1:0] SYNC_END_B  = W'(SYNC_B);
  localparam logic [W-1:0] ACT_START_B = W'(SYNC_B + BACK_B);
  localparam logic [W-1:0] ACT_END_B   = W'(SYNC_B + BACK_B + ACT);
  localparam logic [W-1:0] LAST_B      = W'(SYNC_B + BACK_B + ACT + FRONT_B - 1);

  logic [W-1:0] cnt;
  logic [W-1:0] syncEnd, actStart, actEnd, lastIdx;

  always_comb begin
    syncEnd  = useAlt ? SYNC_END_B  : SYNC_END_A;
    actStart = useAlt ? ACT_START_B : ACT_START_A;
    actEnd   = useAlt ? ACT_END_B   : ACT_END_A;
    lastIdx  = useAlt ? LAST_B      : LAST_A;
  end

  assign inSync = (cnt < syncEnd);
  assign inAct  = (cnt >= actStart) && (cnt < actEnd);
  assign atLast = (cnt == lastIdx);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (advance) cnt <= atLast ? '0 : cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= lastIdx); // R2
  AST_HOLD_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(advance)) |-> $stable(cnt)); // R3

endmodule

// File: rtl/dpvt_ctrl.sv
// Control: horizontal and vertical axes plus the frame-aligned mode register.
module dpvt_ctrl
  import dpvt_pkg::*;
#(
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int H_ACTIVE_PAIRS = 800,
  parameter int H_SYNC_STD  = 96,
  parameter int H_BACK_STD  = 152,
  parameter int H_FRONT_STD = 32,
  parameter int H_SYNC_RB   = 8,
  parameter int H_BACK_RB   = 56,
  parameter int H_FRONT_RB  = 48,
  parameter int V_ACTIVE    = 1200,
  parameter int V_SYNC_STD  = 3,
  parameter int V_BACK_STD  = 46,
  parameter int V_FRONT_STD = 1,
  parameter int V_SYNC_RB   = 1,
  parameter int V_BACK_RB   = 1,
  parameter int V_FRONT_RB  = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           modeSel,
  output rasterStrobes_t strobes
);

  logic curMode;
  logic hLast, vLast, frameEnd;
  logic hSyncZ, hActZ, vSyncZ, vActZ;

  dpvt_axis #(
    .W(HW), .SYNC_A(H_SYNC_STD), .BACK_A(H_BACK_STD), .ACT(H_ACTIVE_PAIRS),
    .FRONT_A(H_FRONT_STD), .SYNC_B(H_SYNC_RB), .BACK_B(H_BACK_RB), .FRONT_B(H_FRONT_RB)
  ) hAxis_i (
    .clk(clk), .rst(rst), .advance(1'b1), .useAlt(curMode),
    .inSync(hSyncZ), .inAct(hActZ), .atLast(hLast)
  );

  dpvt_axis #(
    .W(VW), .SYNC_A(V_SYNC_STD), .BACK_A(V_BACK_STD), .ACT(V_ACTIVE),
    .FRONT_A(V_FRONT_STD), .SYNC_B(V_SYNC_RB), .BACK_B(V_BACK_RB), .FRONT_B(V_FRONT_RB)
  ) vAxis_i (
    .clk(clk), .rst(rst), .advance(hLast), .useAlt(curMode),
    .inSync(vSyncZ), .inAct(vActZ), .atLast(vLast)
  );

  assign frameEnd = hLast & vLast;

  always_ff @(posedge clk) begin
    if (rst)           curMode <= modeSel;
    else if (frameEnd) curMode <= modeSel;
  end

  always_comb begin
    strobes.hSync   = hSyncZ;
    strobes.vSync   = vSyncZ;
    strobes.hAct    = hActZ;
    strobes.vAct    = vActZ;
    strobes.lineEnd = hLast;
  end

  AST_MODE_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && (curMode != $past(curMode))) |-> $past(frameEnd)); // R9

endmodule

// File: rtl/dpvt_datapath.sv
// Datapath: output registers, polarity and pixel-pair / row index counters.
module dpvt_datapath
  import dpvt_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  rasterStrobes_t   strobes,
  input  logic             hPolHigh,
  input  logic             vPolHigh,
  output logic             hSyncQ,
  output logic             vSyncQ,
  output logic             deQ,
  output logic [COL_W-1:0] colQ,
  output logic [ROW_W-1:0] rowQ
);

  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;
  logic             activeNow;

  assign activeNow = strobes.hAct & strobes.vAct;

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt <= '0;
      rowCnt <= '0;
      hSyncQ <= ~hPolHigh;
      vSyncQ <= ~vPolHigh;
      deQ    <= 1'b0;
      colQ   <= '0;
      rowQ   <= '0;
    end else begin
      hSyncQ <= hPolHigh ? strobes.hSync : ~strobes.hSync;
      vSyncQ <= vPolHigh ? strobes.vSync : ~strobes.vSync;
      deQ    <= activeNow;
      colQ   <= activeNow ? colCnt : '0;
      rowQ   <= activeNow ? rowCnt : '0;
      colCnt <= activeNow ? colCnt + 1'b1 : '0;
      if (!strobes.vAct)        rowCnt <= '0;
      else if (strobes.lineEnd) rowCnt <= rowCnt + 1'b1;
    end
  end

  AST_COL_START: assert property (@(posedge clk) disable iff (rst) $rose(deQ) |-> (colQ == '0)); // R5
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst) (deQ && $past(deQ)) |-> (colQ == $past(colQ) + COL_W'(1))); // R5
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst) (deQ && $past(deQ)) |-> (rowQ == $past(rowQ))); // R6
  AST_NO_HSYNC_IN_ACTIVE: assert property (@(posedge clk) disable iff (rst) deQ |-> (hSyncQ != $past(hPolHigh))); // R2

endmodule

// File: rtl/dual_pixel_timing_gen.sv
// Thin top: dual-pixel raster timing generator.
module dual_pixel_timing_gen #(
  parameter int H_ACTIVE_PAIRS = 800,
  parameter int H_SYNC_STD  = 96,
  parameter int H_BACK_STD  = 152,
  parameter int H_FRONT_STD = 32,
  parameter int H_SYNC_RB   = 8,
  parameter int H_BACK_RB   = 56,
  parameter int H_FRONT_RB  = 48,
  parameter int V_ACTIVE    = 1200,
  parameter int V_SYNC_STD  = 3,
  parameter int V_BACK_STD  = 46,
  parameter int V_FRONT_STD = 1,
  parameter int V_SYNC_RB   = 1,
  parameter int V_BACK_RB   = 1,
  parameter int V_FRONT_RB  = 12,
  localparam int COL_W = $clog2(H_ACTIVE_PAIRS),
  localparam int ROW_W = $clog2(V_ACTIVE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeSel,
  input  logic             hSyncPolHigh,
  input  logic             vSyncPolHigh,
  output logic             hSyncOut,
  output logic             vSyncOut,
  output logic             dataEnable,
  output logic [COL_W-1:0] pairCol,
  output logic [ROW_W-1:0] lineRow
);

  localparam int H_TOT_STD = H_SYNC_STD + H_BACK_STD + H_ACTIVE_PAIRS + H_FRONT_STD;
  localparam int H_TOT_RB  = H_SYNC_RB + H_BACK_RB + H_ACTIVE_PAIRS + H_FRONT_RB;
  localparam int V_TOT_STD = V_SYNC_STD + V_BACK_STD + V_ACTIVE + V_FRONT_STD;
  localparam int V_TOT_RB  = V_SYNC_RB + V_BACK_RB + V_ACTIVE + V_FRONT_RB;
  localparam int HW = $clog2((H_TOT_STD > H_TOT_RB) ? H_TOT_STD : H_TOT_RB);
  localparam int VW = $clog2((V_TOT_STD > V_TOT_RB) ? V_TOT_STD : V_TOT_RB);

  dpvt_pkg::rasterStrobes_t strobes;

  dpvt_ctrl #(
    .HW(HW), .VW(VW), .H_ACTIVE_PAIRS(H_ACTIVE_PAIRS),
    .H_SYNC_STD(H_SYNC_STD), .H_BACK_STD(H_BACK_STD), .H_FRONT_STD(H_FRONT_STD),
    .H_SYNC_RB(H_SYNC_RB), .H_BACK_RB(H_BACK_RB), .H_FRONT_RB(H_FRONT_RB),
    .V_ACTIVE(V_ACTIVE),
    .V_SYNC_STD(V_SYNC_STD), .V_BACK_STD(V_BACK_STD), .V_FRONT_STD(V_FRONT_STD),
    .V_SYNC_RB(V_SYNC_RB), .V_BACK_RB(V_BACK_RB), .V_FRONT_RB(V_FRONT_RB)
  ) ctrl_i (
    .clk(clk), .rst(rst), .modeSel(modeSel), .strobes(strobes)
  );

  dpvt_datapath #(.COL_W(COL_W), .ROW_W(ROW_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .hPolHigh(hSyncPolHigh), .vPolHigh(vSyncPolHigh),
    .hSyncQ(hSyncOut), .vSyncQ(vSyncOut), .deQ(dataEnable),
    .colQ(pairCol), .rowQ(lineRow)
  );

endmodule

// File: tb/dual_pixel_timing_gen_tb_top.sv
module dual_pixel_timing_gen_tb_top;

  // Shrunken lengths so that many frame boundaries fit in one run
  localparam int H_ACT = 6, HS_S = 2, HB_S = 3, HF_S = 1, HS_R = 1, HB_R = 2, HF_R = 4;
  localparam int V_ACT = 4, VS_S = 2, VB_S = 1, VF_S = 1, VS_R = 1, VB_R = 1, VF_R = 3;
  localparam int COL_W = $clog2(H_ACT);
  localparam int ROW_W = $clog2(V_ACT);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, modeSel, hPol, vPol;
  logic hSyncOut, vSyncOut, dataEnable;
  logic [COL_W-1:0] pairCol;
  logic [ROW_W-1:0] lineRow;

  dual_pixel_timing_gen #(
    .H_ACTIVE_PAIRS(H_ACT), .H_SYNC_STD(HS_S), .H_BACK_STD(HB_S), .H_FRONT_STD(HF_S),
    .H_SYNC_RB(HS_R), .H_BACK_RB(HB_R), .H_FRONT_RB(HF_R),
    .V_ACTIVE(V_ACT), .V_SYNC_STD(VS_S), .V_BACK_STD(VB_S), .V_FRONT_STD(VF_S),
    .V_SYNC_RB(VS_R), .V_BACK_RB(VB_R), .V_FRONT_RB(VF_R)
  ) dut_i (
    .clk(clk), .rst(rst), .modeSel(modeSel),
    .hSyncPolHigh(hPol), .vSyncPolHigh(vPol),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .dataEnable(dataEnable),
    .pairCol(pairCol), .lineRow(lineRow)
  );

  int nVec = 0;
  int nBad = 0;
  int mH = 0, mV = 0, mMode = 0;
  int eHs, eVs, eDe, eCol, eRow;
  string tH, tV, tD, tC, tR;

  function automatic int hSyncLen(int m);  return m != 0 ? HS_R : HS_S; endfunction
  function automatic int hBackLen(int m);  return m != 0 ? HB_R : HB_S; endfunction
  function automatic int hFrontLen(int m); return m != 0 ? HF_R : HF_S; endfunction
  function automatic int vSyncLen(int m);  return m != 0 ? VS_R : VS_S; endfunction
  function automatic int vBackLen(int m);  return m != 0 ? VB_R : VB_S; endfunction
  function automatic int vFrontLen(int m); return m != 0 ? VF_R : VF_S; endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: got %0d expected %0d (line %0d clock %0d)", tag, what, act, exp, mV, mH);
    end
  endtask

  // Model of one rising edge, using the inputs held since the last falling edge
  task automatic edgeModel();
    if (rst) begin
      mH = 0; mV = 0; mMode = modeSel ? 1 : 0;
      eHs = hPol ? 0 : 1; eVs = vPol ? 0 : 1; eDe = 0; eCol = 0; eRow = 0;
      tH = "R1"; tV = "R1"; tD = "R1"; tC = "R1"; tR = "R1";
    end else begin
      int hAS = hSyncLen(mMode) + hBackLen(mMode);
      int vAS = vSyncLen(mMode) + vBackLen(mMode);
      int hTot = hAS + H_ACT + hFrontLen(mMode);
      int vTot = vAS + V_ACT + vFrontLen(mMode);
      bit hA = (mH >= hAS) && (mH < hAS + H_ACT);
      bit vA = (mV >= vAS) && (mV < vAS + V_ACT);
      bit hS = mH < hSyncLen(mMode);
      bit vS = mV < vSyncLen(mMode);
      eHs = (hS == hPol) ? 1 : 0;
      eVs = (vS == vPol) ? 1 : 0;
      eDe = (hA && vA) ? 1 : 0;
      eCol = eDe != 0 ? mH - hAS : 0;
      eRow = eDe != 0 ? mV - vAS : 0;
      tH = !hPol ? "R8" : (mMode != 0 ? "R9" : "R2");
      tV = !vPol ? "R8" : (mMode != 0 ? "R9" : "R3");
      tD = "R4";
      tC = eDe != 0 ? "R5" : "R7";
      tR = eDe != 0 ? "R6" : "R7";
      if (mH == hTot - 1) begin
        mH = 0;
        if (mV == vTot - 1) begin
          mV = 0;
          mMode = modeSel ? 1 : 0;
        end else mV++;
      end else mH++;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    edgeModel();
    @(negedge clk);
    chk(tH, "hsync", int'(hSyncOut), eHs);
    chk(tV, "vsync", int'(vSyncOut), eVs);
    chk(tD, "data enable", int'(dataEnable), eDe);
    chk(tC, "pair column", int'(pairCol), eCol);
    chk(tR, "row", int'(lineRow), eRow);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R1: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240611);
    rst = 1'b1; modeSel = 1'b0; hPol = 1'b1; vPol = 1'b1;
    repeat (3) cyc();                       // R1 reset state
    rst = 1'b0;
    repeat (3 * 12 * 8) cyc();              // R2 R3 R4 R5 R6 R7 standard preset, active-high
    hPol = 1'b0; vPol = 1'b0;
    repeat (12 * 8) cyc();                  // R8 active-low syncs
    hPol = 1'b1; vPol = 1'b1;
    repeat (30) cyc();
    modeSel = 1'b1;                         // R9 mid-frame request, deferred to frame end
    repeat (3 * 13 * 9) cyc();
    repeat (17) cyc();
    rst = 1'b1;                             // R1 reset in mid-frame, mode reloaded
    modeSel = 1'b0;
    cyc();
    rst = 1'b0;
    repeat (12 * 8 + 5) cyc();
    for (int i = 0; i < 3000; i++) begin    // random mix: mode, polarity, reset
      if ($urandom_range(49) == 0) modeSel = ~modeSel;
      if ($urandom_range(79) == 0) hPol = ~hPol;
      if ($urandom_range(79) == 0) vPol = ~vPol;
      rst = ($urandom_range(499) == 0);
      cyc();
    end
    rst = 1'b0;
    repeat (200) cyc();
    if (seedVal == 0) $display("seed value zero");
    summary();
    $finish;
  end

endmodule